// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Datapath

This block turns raw front-end samples from a group of calorimeter channels into one compressed transverse-energy trigger word per bunch crossing. Each channel's 7-bit nonlinear code goes through a shared input table. The table returns a 10-bit linear energy and a muon tag. The block adds the channel energies with saturation and ORs the muon tags. A three-sample window then finds the bunch crossing that holds the energy peak. Only that crossing keeps its energy, and the energy goes through a compression table to an 8-bit trigger value. A shower-veto table, indexed by the upper bits of the summed energy, can clear a muon tag that shower leakage from a neighbouring cell has raised.

Software reaches all three tables through one small register port. It may rewrite them only while the datapath is held idle (`run` low), and it can read every entry back one cycle after addressing it. While `run` is low, the pipeline freezes and keeps its contents. When `run` returns, processing resumes exactly where it stopped.

Top module: `trig_prim_path`

## Requirements
- R1: After reset, the input table is the identity: code c gives energy c and muon tag 0. It is read back with `cfg_sel`=0 as {muon, energy} on `cfg_rdata` bits [10] and [9:0].
- R2: After reset, compression entry e holds min(e,255) and every veto entry is 0. Compression is read with `cfg_sel`=2 on `cfg_rdata[7:0]`. The veto table is read with `cfg_sel`=1 on `cfg_rdata[0]`.
- R3: A write with `cfg_sel`=0 stores `cfg_wdata[9:0]` as the energy and `cfg_wdata[10]` as the muon tag for code `cfg_addr[6:0]`. Samples that enter afterwards use the new entry.
- R4: The channel energies are summed, and any sum above 1023 is clamped to 1023 instead of wrapping.
- R5: A crossing is a peak when its sum is strictly greater than the previous crossing's sum and greater than or equal to the next crossing's sum. A non-peak crossing gives `tp_et`=0.
- R6: A peak crossing gives `tp_et` equal to the compression-table entry addressed by its 10-bit sum.
- R7: `tp_mu` is the OR of the channel muon tags for the crossing. It is forced to 0 when the veto entry at sum[9:5] is 1. The veto is written with `cfg_sel`=1 from `cfg_wdata[0]` at `cfg_addr[4:0]`.
- R8: Table writes take effect only while `run` is 0. A write attempted while `run` is 1 changes nothing.
- R9: `cfg_rdata` shows the addressed entry one clock after `cfg_sel`/`cfg_addr` are presented. `cfg_sel`=3 reads 0.
- R10: Each clock with `run`=1 advances the pipeline by one crossing. `tp_valid` is 1 in the cycle after every such clock and 0 otherwise. The result for the sample taken at the k-th `run` clock appears after the (k+4)-th `run` clock. Clocks with `run`=0 hold all pipeline state and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance the datapath this cycle; table writes are blocked while high |
| fe_code | input | NCH*7 | Front-end codes, channel c at bits [c*7 +: 7] |
| cfg_sel | input | 2 | Table select: 0 input, 1 veto, 2 compression |
| cfg_addr | input | 10 | Table entry address |
| cfg_we | input | 1 | Table write strobe |
| cfg_wdata | input | 11 | Write data, field layout per table |
| cfg_rdata | output | 11 | Registered read-back of the addressed entry |
| tp_valid | output | 1 | Trigger word updated this cycle |
| tp_et | output | 8 | Compressed trigger energy |
| tp_mu | output | 1 | Muon flag after veto |

## Verification
Several behaviours are checked on every cycle. The assertions confirm that idle cycles neither raise `tp_valid` nor move the outputs, and that a write issued during running leaves the compression table untouched. They also confirm that the clamped sum never falls below a channel's energy, that a zero-energy crossing never yields trigger energy, and that a crossing without a muon tag never reports one. The bench's scenarios cover the rest. Whole peak-finding sequences, including a plateau of equal samples, show the exact latency across a pause in `run`. Reprogrammed tables show saturation reaching the top compression entry, and a veto written between two bursts shows the same muon crossing first kept and then cleared.

// File: rtl/trig_prim_path.sv
module trig_prim_path #(
  parameter int NCH    = 2,
  parameter int CODE_W = 7,
  parameter int LIN_W  = 10,
  parameter int ET_W   = 8,
  parameter int VETO_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [NCH*CODE_W-1:0] fe_code,
  input  logic [1:0]            cfg_sel,
  input  logic [LIN_W-1:0]      cfg_addr,
  input  logic                  cfg_we,
  input  logic [LIN_W:0]        cfg_wdata,
  output logic [LIN_W:0]        cfg_rdata,
  output logic                  tp_valid,
  output logic [ET_W-1:0]       tp_et,
  output logic                  tp_mu
);
  localparam int IN_DEPTH   = 1 << CODE_W;
  localparam int OUT_DEPTH  = 1 << LIN_W;
  localparam int VETO_DEPTH = 1 << VETO_W;
  localparam int SUM_W      = LIN_W + $clog2(NCH) + 1;
  localparam logic [LIN_W-1:0] LIN_MAX = '1;

  logic [LIN_W:0]          in_lut  [IN_DEPTH];
  logic [ET_W-1:0]         cmp_lut [OUT_DEPTH];
  logic [VETO_DEPTH-1:0]   veto_map;

  wire host_wr = cfg_we & ~run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < IN_DEPTH; i++) in_lut[i] <= {1'b0, LIN_W'(i)};
      for (int i = 0; i < OUT_DEPTH; i++)
        cmp_lut[i] <= (i >= (1 << ET_W)) ? {ET_W{1'b1}} : ET_W'(i);
      veto_map <= '0;
    end else if (host_wr) begin
      case (cfg_sel)
        2'd0: in_lut[cfg_addr[CODE_W-1:0]] <= cfg_wdata;
        2'd1: veto_map[cfg_addr[VETO_W-1:0]] <= cfg_wdata[0];
        2'd2: cmp_lut[cfg_addr] <= cfg_wdata[ET_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_rdata <= '0;
    else begin
      case (cfg_sel)
        2'd0:    cfg_rdata <= in_lut[cfg_addr[CODE_W-1:0]];
        2'd1:    cfg_rdata <= (LIN_W+1)'(veto_map[cfg_addr[VETO_W-1:0]]);
        2'd2:    cfg_rdata <= (LIN_W+1)'(cmp_lut[cfg_addr]);
        default: cfg_rdata <= '0;
      endcase
    end
  end

  logic [LIN_W-1:0] lin_q [NCH];
  logic [NCH-1:0]   lmu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) lin_q[c] <= '0;
      lmu_q <= '0;
    end else if (run) begin
      for (int c = 0; c < NCH; c++)
        {lmu_q[c], lin_q[c]} <= in_lut[fe_code[c*CODE_W +: CODE_W]];
    end
  end

  logic [SUM_W-1:0] raw_sum;
  always_comb begin
    raw_sum = '0;
    for (int c = 0; c < NCH; c++) raw_sum = raw_sum + SUM_W'(lin_q[c]);
  end
  wire [LIN_W-1:0] sat_sum = (raw_sum > SUM_W'(LIN_MAX)) ? LIN_MAX : raw_sum[LIN_W-1:0];

  logic [LIN_W-1:0] sum_q, nxt_q, cur_q, prv_q;
  logic             smu_q, nxt_mu, cur_mu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sum_q, nxt_q, cur_q, prv_q} <= '0;
      {smu_q, nxt_mu, cur_mu}      <= '0;
    end else if (run) begin
      sum_q  <= sat_sum;
      smu_q  <= |lmu_q;
      nxt_q  <= sum_q;
      nxt_mu <= smu_q;
      cur_q  <= nxt_q;
      cur_mu <= nxt_mu;
      prv_q  <= cur_q;
    end
  end

  wire is_peak = (cur_q > prv_q) && (cur_q >= nxt_q);
  wire vetoed  = veto_map[cur_q[LIN_W-1 -: VETO_W]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp_valid <= 1'b0;
      tp_et    <= '0;
      tp_mu    <= 1'b0;
    end else begin
      tp_valid <= run;
      if (run) begin
        tp_et <= is_peak ? cmp_lut[cur_q] : '0;
        tp_mu <= cur_mu & ~vetoed;
      end
    end
  end

  wire [LIN_W-1:0] lin0 = lin_q[0];

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tp_valid && $stable(tp_et) && $stable(tp_mu));

  // R8
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && cfg_we && cfg_sel == 2'd2 |=>
      cmp_lut[$past(cfg_addr)] == $past(cmp_lut[cfg_addr]));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> sum_q >= $past(lin0));

  // R5
  zero_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && cur_q == '0 |=> tp_et == '0);

  // R7
  mu_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cur_mu |=> !tp_mu);
endmodule

// File: tb/trig_prim_path_bench.sv
module trig_prim_path_bench;
  localparam int CLK_NS = 10;
  localparam int NCH = 2;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, cfg_we = 1'b0;
  logic [NCH*7-1:0] fe_code = '0;
  logic [1:0] cfg_sel = '0;
  logic [9:0] cfg_addr = '0;
  logic [10:0] cfg_wdata = '0;
  logic [10:0] cfg_rdata;
  logic tp_valid, tp_mu;
  logic [7:0] tp_et;

  always #(CLK_NS/2) clk = ~clk;

  trig_prim_path u_trig_prim_path (
    .clk(clk), .rst_n(rst_n), .run(run), .fe_code(fe_code),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tp_valid(tp_valid), .tp_et(tp_et), .tp_mu(tp_mu));

  typedef struct { int s; bit m; } item_t;
  item_t q[$];
  item_t w_prv, w_cur;
  int b_in_e[128];
  bit b_in_m[128];
  int b_cmp[1024];
  bit b_veto[32];
  int n_chk = 0, n_bad = 0;
  bit mon_on = 0, done = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_wr(int sel, int addr, int data);
    @(negedge clk);
    run = 0; cfg_sel = 2'(sel); cfg_addr = 10'(addr); cfg_wdata = 11'(data); cfg_we = 1;
    if (sel == 0) begin b_in_e[addr] = data & 1023; b_in_m[addr] = data[10]; end
    else if (sel == 1) b_veto[addr] = data[0];
    else if (sel == 2) b_cmp[addr] = data & 255;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(int sel, int addr, int exp, string tag);
    @(negedge clk);
    run = 0; cfg_we = 0; cfg_sel = 2'(sel); cfg_addr = 10'(addr);
    @(negedge clk);
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic drive(int c0, int c1, bit wr_try = 0);
    item_t it;
    @(negedge clk);
    run = 1; fe_code = {7'(c1), 7'(c0)};
    it.s = b_in_e[c0] + b_in_e[c1];
    if (it.s > 1023) it.s = 1023;
    it.m = b_in_m[c0] | b_in_m[c1];
    q.push_back(it);
    if (wr_try) begin cfg_sel = 2; cfg_addr = 60; cfg_wdata = 7; cfg_we = 1; end
    else cfg_we = 0;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) drive(0, 0);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    run = 0; cfg_we = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R10 tp_valid while idle", int'(tp_valid), 0);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && tp_valid) begin
      item_t nx;
      int exp_et;
      bit exp_mu;
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 unexpected output actual=valid expected=none");
      end else begin
        nx = q.pop_front();
        exp_et = (w_cur.s > w_prv.s && w_cur.s >= nx.s) ? b_cmp[w_cur.s] : 0;
        exp_mu = w_cur.m & !b_veto[w_cur.s >> 5];
        check("R4/R5/R6/R10 tp_et", int'(tp_et), exp_et);
        check("R3/R7 tp_mu", int'(tp_mu), int'(exp_mu));
        w_prv = w_cur;
        w_cur = nx;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    item_t z;
    z.s = 0; z.m = 0;
    for (int i = 0; i < 128; i++) begin b_in_e[i] = i; b_in_m[i] = 0; end
    for (int i = 0; i < 1024; i++) b_cmp[i] = (i > 255) ? 255 : i;
    for (int i = 0; i < 32; i++) b_veto[i] = 0;
    for (int i = 0; i < 3; i++) q.push_back(z);
    w_prv = z; w_cur = z;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset tp_valid", int'(tp_valid), 0);
    check("R10 reset tp_et", int'(tp_et), 0);
    check("R10 reset tp_mu", int'(tp_mu), 0);
    mon_on = 1;

    rd(0, 5, 5, "R1 input entry 5");
    rd(0, 127, 127, "R1 input entry 127");
    rd(2, 100, 100, "R2 compression entry 100");
    rd(2, 300, 255, "R2 compression entry 300");
    rd(1, 3, 0, "R2 veto entry 3");
    rd(3, 9, 0, "R9 unused select");

    // identity path, peak, pause inside burst, plateau
    drive(10, 5); drive(40, 20);
    idle(3);
    drive(30, 10); drive(5, 0); drive(0, 0);
    drive(20, 0); drive(20, 0, 1); drive(0, 0);
    flush();
    idle(2);
    rd(2, 60, 60, "R8 write during run ignored");

    // reprogram tables: saturation, muon tags
    host_wr(0, 100, (1 << 10) | 900);
    host_wr(0, 102, (1 << 10) | 10);
    host_wr(2, 1023, 200);
    rd(0, 100, (1 << 10) | 900, "R3 input entry readback");
    rd(2, 1023, 200, "R8 idle write accepted");
    drive(100, 100); drive(0, 0); drive(102, 0); drive(50, 0); drive(0, 0);
    flush();
    idle(2);

    // veto on saturated energy
    host_wr(1, 31, 1);
    rd(1, 31, 1, "R7 veto readback");
    drive(100, 100); drive(0, 0); drive(102, 0);
    flush();
    idle(4);

    done = 1;
    summary();
    $finish;
  end
endmodule